// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the software-facing register file of a four-channel DMA controller. A host reaches it over a narrow 8-bit I/O port bus with a chip select, a read strobe, a write strobe and a 4-bit port number. Each channel keeps a 16-bit start address and a 16-bit transfer count in two copies: a base copy that holds what software wrote, and a current copy that a transfer engine advances. Since the bus is only a byte wide, each 16-bit value is moved as two byte accesses to the same port. A single byte-pointer bit shared by all channels decides whether an access touches the low half or the high half.

Next to the per-channel values sit the control ports. These are a command byte, a software request per channel, a mask per channel (set one at a time, clear all at once, or load all four), a mode per channel, a clear-pointer port, a master clear, and a status byte that holds request and terminal-count flags. The transfer engine reads masks, modes, requests and programmed values from the output ports. It pulses one step line per transfer. On each step the current copies advance, a terminal count is flagged when it is reached, and the current copies reload from the base copies when the mode asks for it.

Top module: `dma_prog_regs`

## Requirements
- R1: After reset all four channels are masked (mask_o = 4'b1111), mode_o, cmd_o and req_o are zero, all address and count copies are zero, the byte pointer selects the low byte, and rdata_o is 0x00 whenever no read strobe is active.
- R2: Port 2n holds the address of channel n and port 2n+1 holds its count. A write loads both the base copy and the current copy, low byte on the first access and high byte on the second.
- R3: One byte pointer is shared by every channel. Each read or write of ports 0x0 to 0x7 toggles it. A write of any value to port 0xC forces it back to the low byte.
- R4: A read of ports 0x0 to 0x7 returns the current copy of that address or count, one byte per access, in the same order as writes.
- R5: A write to port 0xA selects a channel with data[1:0]. data[2]=1 masks that channel and data[2]=0 unmasks it. The other channels keep their masks.
- R6: A write to port 0xE unmasks all channels. A write to port 0xF loads data[3:0] as the four mask bits (bit n for channel n).
- R7: A write to port 0xB selects a channel with data[1:0] and stores data[7:2] as that channel's 6-bit mode on mode_o[6n+5:6n]. Mode bit 3 (data[5]) sets address decrement and mode bit 2 (data[4]) sets autoinitialize.
- R8: A write of any value to port 0xD is a master clear. It masks all channels, zeroes all modes, the command byte, the requests and the terminal-count flags, and returns the byte pointer to the low byte.
- R9: A write to port 0x9 selects a channel with data[1:0] and sets (data[2]=1) or clears (data[2]=0) its software request. The requests appear on req_o and in status bits [7:4].
- R10: A read of port 0x8 returns {requests[3:0], terminal-count flags[3:0]} and then clears the terminal-count flags. A flag raised in the same cycle as that read survives it.
- R11: A step on an unmasked channel lowers its current count by one and moves its current address by one, up or down as the mode selects. A step on a masked channel changes nothing.
- R12: A step when the current count is 0x0000 sets that channel's terminal-count flag, so a stored count N gives N+1 transfers. Without autoinitialize the count wraps to 0xFFFF. With autoinitialize both current copies reload from the base copies.
- R13: A write to port 0x8 stores the command byte on cmd_o. Reads of port 0xD and of the other write-only ports return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, one access per clock while high |
| wr_i | input | 1 | Write strobe, one access per clock while high |
| addr_i | input | 4 | Port number |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational during a read |
| step_i | input | 4 | Per-channel transfer pulse from the engine |
| mask_o | output | 4 | Per-channel mask, 1 = disabled |
| mode_o | output | 24 | Six mode bits per channel |
| cmd_o | output | 8 | Command byte |
| req_o | output | 4 | Software requests |
| base_addr_o | output | 64 | Base address per channel |
| cur_addr_o | output | 64 | Current address per channel |
| base_cnt_o | output | 64 | Base count per channel |
| cur_cnt_o | output | 64 | Current count per channel |

## Verification
The byte pointer is the state most likely to go wrong, and it cannot be seen directly. A pointer that is off by one access swaps the two halves of the next byte read or written, so the bench runs mixed write and read sequences across several channels and reads back values whose two bytes differ. A wrong mask, mode or request shows on the output ports one cycle after the write. A wrong count or flag shows at the first step that follows, or at the next status read, because that read returns and clears the flags. The bench steps channels through the zero count with and without reload, and raises a flag in the same cycle as a status read.

// File: rtl/dma_prog_pkg.sv
package dma_prog_pkg;

    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 6;

    typedef enum logic [3:0] {
        P_CMDSTAT = 4'h8,
        P_REQ     = 4'h9,
        P_MASK1   = 4'hA,
        P_MODE    = 4'hB,
        P_CLRPTR  = 4'hC,
        P_MCLR    = 4'hD,
        P_CLRMASK = 4'hE,
        P_MASKALL = 4'hF
    } ctl_port_e;

    typedef struct packed {
        logic [1:0] sel;
        logic       dec;
        logic       autoinit;
        logic [1:0] xfer;
    } mode_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                    input logic hi);
        return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic toggle,
    output logic hi
);
    always_ff @(posedge clk) begin
        if (rst || clr) hi <= 1'b0;
        else if (toggle) hi <= ~hi;
    end

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> !hi); // R3
    AST_PTR_FLIP: assert property (@(posedge clk) disable iff (rst)
        (toggle && !clr) |=> (hi != $past(hi))); // R3
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic              hi,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              step,
    input  logic              masked,
    input  logic              dec,
    input  logic              autoinit,
    output logic [WORD_W-1:0] base_addr,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] base_cnt,
    output logic [WORD_W-1:0] cur_cnt,
    output logic              tc_set
);
    logic go;
    logic at_zero;

    assign go      = step && !masked && !ld_addr && !ld_cnt;
    assign at_zero = (cur_cnt == '0);
    assign tc_set  = go && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
        end else begin
            if (ld_addr) begin
                if (hi) begin
                    base_addr[WORD_W-1:BYTE_W] <= wbyte;
                    cur_addr[WORD_W-1:BYTE_W]  <= wbyte;
                end else begin
                    base_addr[BYTE_W-1:0] <= wbyte;
                    cur_addr[BYTE_W-1:0]  <= wbyte;
                end
            end
            if (ld_cnt) begin
                if (hi) begin
                    base_cnt[WORD_W-1:BYTE_W] <= wbyte;
                    cur_cnt[WORD_W-1:BYTE_W]  <= wbyte;
                end else begin
                    base_cnt[BYTE_W-1:0] <= wbyte;
                    cur_cnt[BYTE_W-1:0]  <= wbyte;
                end
            end
            if (go) begin
                if (at_zero && autoinit) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    cur_addr <= dec ? cur_addr - 1'b1 : cur_addr + 1'b1;
                    cur_cnt  <= cur_cnt - 1'b1;
                end
            end
        end
    end

    AST_LOAD_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (ld_cnt && !hi) |=> (base_cnt[BYTE_W-1:0] == cur_cnt[BYTE_W-1:0])); // R2
    AST_STEP_CNT: assert property (@(posedge clk) disable iff (rst)
        (step && !masked && !ld_addr && !ld_cnt && cur_cnt != '0)
        |=> (cur_cnt == $past(cur_cnt) - 1'b1)); // R11
    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (masked && !ld_addr && !ld_cnt) |=> ($stable(cur_cnt) && $stable(cur_addr))); // R11
    AST_TC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !masked && !ld_addr && !ld_cnt && cur_cnt == '0 && !autoinit)
        |=> (cur_cnt == '1)); // R12
    AST_TC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (step && !masked && !ld_addr && !ld_cnt && cur_cnt == '0 && autoinit)
        |=> (cur_cnt == $past(base_cnt) && cur_addr == $past(base_addr))); // R12
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_prog_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [3:0]               addr,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic [NUM_CH-1:0]        tc_set,
    output logic [NUM_CH-1:0]        mask,
    output mode_t [NUM_CH-1:0]       mode,
    output logic [BYTE_W-1:0]        cmd,
    output logic [NUM_CH-1:0]        req,
    output logic [BYTE_W-1:0]        status,
    output logic                     ptr_clr
);
    logic              mclr;
    logic              stat_rd;
    logic [NUM_CH-1:0] tc;
    logic [CH_W-1:0]   sel;

    assign sel     = wdata[CH_W-1:0];
    assign mclr    = wr_en && (addr == P_MCLR);
    assign stat_rd = rd_en && (addr == P_CMDSTAT);
    assign ptr_clr = wr_en && ((addr == P_CLRPTR) || (addr == P_MCLR));
    assign status  = {req, tc};

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            mask <= '1;
            mode <= '0;
            cmd  <= '0;
            req  <= '0;
            tc   <= '0;
        end else begin
            tc <= (stat_rd ? '0 : tc) | tc_set;
            if (wr_en) begin
                case (addr)
                    P_CMDSTAT: cmd       <= wdata;
                    P_REQ:     req[sel]  <= wdata[2];
                    P_MASK1:   mask[sel] <= wdata[2];
                    P_MODE:    mode[sel] <= mode_t'(wdata[BYTE_W-1:2]);
                    P_CLRMASK: mask      <= '0;
                    P_MASKALL: mask      <= wdata[NUM_CH-1:0];
                    default: ;
                endcase
            end
        end
    end

    AST_MCLR_MASK: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (mask == '1 && mode == '0 && req == '0)); // R8
    AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|tc_set && !mclr) |=> (|tc)); // R10
    AST_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && tc_set == '0) |=> (tc == '0)); // R10
    AST_CLRMASK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == P_CLRMASK) |=> (mask == '0)); // R6
endmodule

// File: rtl/dma_prog_regs.sv
module dma_prog_regs
    import dma_prog_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs_i,
    input  logic                       rd_i,
    input  logic                       wr_i,
    input  logic [3:0]                 addr_i,
    input  logic [BYTE_W-1:0]          wdata_i,
    output logic [BYTE_W-1:0]          rdata_o,
    input  logic [NUM_CH-1:0]          step_i,
    output logic [NUM_CH-1:0]          mask_o,
    output logic [NUM_CH*MODE_W-1:0]   mode_o,
    output logic [BYTE_W-1:0]          cmd_o,
    output logic [NUM_CH-1:0]          req_o,
    output logic [NUM_CH*WORD_W-1:0]   base_addr_o,
    output logic [NUM_CH*WORD_W-1:0]   cur_addr_o,
    output logic [NUM_CH*WORD_W-1:0]   base_cnt_o,
    output logic [NUM_CH*WORD_W-1:0]   cur_cnt_o
);
    logic wr_en, rd_en, chan_port, ptr_hi, ptr_clr;
    logic [CH_W-1:0]                 port_ch;
    logic [NUM_CH-1:0]               tc_set;
    logic [NUM_CH-1:0]               mask_q;
    mode_t [NUM_CH-1:0]              mode_q;
    logic [BYTE_W-1:0]               status;
    logic [NUM_CH-1:0][WORD_W-1:0]   base_addr_w, cur_addr_w, base_cnt_w, cur_cnt_w;

    assign wr_en     = cs_i && wr_i;
    assign rd_en     = cs_i && rd_i && !wr_i;
    assign chan_port = !addr_i[3];
    assign port_ch   = addr_i[CH_W:1];

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .clr    (ptr_clr),
        .toggle ((wr_en || rd_en) && chan_port),
        .hi     (ptr_hi)
    );

    dma_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr_i),
        .wdata   (wdata_i),
        .tc_set  (tc_set),
        .mask    (mask_q),
        .mode    (mode_q),
        .cmd     (cmd_o),
        .req     (req_o),
        .status  (status),
        .ptr_clr (ptr_clr)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic sel_me;
        assign sel_me = wr_en && chan_port && (port_ch == CH_W'(n));
        dma_chan_regs u_ch (
            .clk       (clk),
            .rst       (rst),
            .ld_addr   (sel_me && !addr_i[0]),
            .ld_cnt    (sel_me && addr_i[0]),
            .hi        (ptr_hi),
            .wbyte     (wdata_i),
            .step      (step_i[n]),
            .masked    (mask_q[n]),
            .dec       (mode_q[n].dec),
            .autoinit  (mode_q[n].autoinit),
            .base_addr (base_addr_w[n]),
            .cur_addr  (cur_addr_w[n]),
            .base_cnt  (base_cnt_w[n]),
            .cur_cnt   (cur_cnt_w[n]),
            .tc_set    (tc_set[n])
        );
    end

    assign mask_o      = mask_q;
    assign mode_o      = mode_q;
    assign base_addr_o = base_addr_w;
    assign cur_addr_o  = cur_addr_w;
    assign base_cnt_o  = base_cnt_w;
    assign cur_cnt_o   = cur_cnt_w;

    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            if (chan_port)
                rdata_o = pick_byte(addr_i[0] ? cur_cnt_w[port_ch] : cur_addr_w[port_ch], ptr_hi);
            else if (addr_i == P_CMDSTAT)
                rdata_o = status;
        end
    end

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(cs_i && rd_i) |-> (rdata_o == '0)); // R1
    AST_WRONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr_i[3] && addr_i != P_CMDSTAT) |-> (rdata_o == '0)); // R13
endmodule

// File: tb/dma_prog_regs_tb_top.sv
module dma_prog_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_i = 0, rd_i = 0, wr_i = 0;
    logic [3:0]  addr_i = 0;
    logic [7:0]  wdata_i = 0;
    logic [7:0]  rdata_o;
    logic [3:0]  step_i = 0;
    logic [3:0]  mask_o;
    logic [23:0] mode_o;
    logic [7:0]  cmd_o;
    logic [3:0]  req_o;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dma_prog_regs dut_i (
        .clk(clk), .rst(rst), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .step_i(step_i),
        .mask_o(mask_o), .mode_o(mode_o), .cmd_o(cmd_o), .req_o(req_o),
        .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
        .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o)
    );

    // {is_read, port, data-or-expected}
    localparam int NV = 23;
    localparam logic [12:0] VEC [0:NV-1] = '{
        {1'b0, 4'hC, 8'h00},  // pointer to low
        {1'b0, 4'h0, 8'h34},  // R2 ch0 address low
        {1'b0, 4'h0, 8'h12},  // R2 ch0 address high
        {1'b0, 4'h3, 8'h05},  // R2 ch1 count low
        {1'b0, 4'h3, 8'h00},  // R2 ch1 count high
        {1'b1, 4'h0, 8'h34},  // R4
        {1'b1, 4'h0, 8'h12},  // R4
        {1'b1, 4'h3, 8'h05},  // R4
        {1'b1, 4'h3, 8'h00},  // R4
        {1'b0, 4'h0, 8'hAA},  // low byte, pointer goes high
        {1'b0, 4'hC, 8'h5F},  // R3 clear pointer, any value
        {1'b1, 4'h0, 8'hAA},  // R3
        {1'b1, 4'h0, 8'h12},  // R3
        {1'b0, 4'h4, 8'h77},  // R3 ch2 low
        {1'b0, 4'h6, 8'h99},  // R3 shared pointer: ch3 high
        {1'b1, 4'h6, 8'h00},  // R3
        {1'b1, 4'h6, 8'h99},  // R3
        {1'b0, 4'h9, 8'h06},  // R9 request ch2
        {1'b1, 4'h8, 8'h40},  // R9 status
        {1'b0, 4'h9, 8'h02},  // R9 clear ch2
        {1'b1, 4'h8, 8'h00},  // R9
        {1'b1, 4'hD, 8'h00},  // R13 temp read
        {1'b1, 4'hB, 8'h00}   // R13 write-only port
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
        @(posedge clk); #1;
        cs_i = 0; wr_i = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_i = 1; rd_i = 1; addr_i = a;
        #2 d = rdata_o;
        @(posedge clk); #1;
        cs_i = 0; rd_i = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] e);
        logic [7:0] d;
        bus_rd(a, d);
        chk(tag, {24'h0, d}, {24'h0, e});
    endtask

    task automatic do_step(input logic [3:0] m);
        @(negedge clk);
        step_i = m;
        @(posedge clk); #1;
        step_i = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 mask", {28'h0, mask_o}, 32'hF);
        chk("R1 mode", {8'h0, mode_o}, 32'h0);
        chk("R1 cmd/req", {20'h0, cmd_o, req_o}, 32'h0);
        chk("R1 count", cur_cnt_o[31:0], 32'h0);
        chk("R1 idle rdata", {24'h0, rdata_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) rd_chk($sformatf("vector %0d R4/R3/R9/R13", i), VEC[i][11:8], VEC[i][7:0]);
            else bus_wr(VEC[i][11:8], VEC[i][7:0]);
        end

        @(negedge clk);
        chk("R2 ch0 base addr", {16'h0, base_addr_o[15:0]}, 32'h12AA);
        chk("R2 ch0 cur addr", {16'h0, cur_addr_o[15:0]}, 32'h12AA);
        chk("R2 ch1 base cnt", {16'h0, base_cnt_o[31:16]}, 32'h0005);

        bus_wr(4'hB, 8'h49);
        @(negedge clk);
        chk("R7 ch1 mode", {26'h0, mode_o[11:6]}, 32'h12);
        chk("R7 ch0 mode kept", {26'h0, mode_o[5:0]}, 32'h0);

        bus_wr(4'h3, 8'h01); bus_wr(4'h3, 8'h00);
        bus_wr(4'h2, 8'h10); bus_wr(4'h2, 8'h00);
        do_step(4'b0010);
        @(negedge clk);
        chk("R11 masked step ignored", {16'h0, cur_cnt_o[31:16]}, 32'h0001);
        bus_wr(4'hA, 8'h01);
        @(negedge clk);
        chk("R5 unmask ch1", {28'h0, mask_o}, 32'hD);

        do_step(4'b0010);
        @(negedge clk);
        chk("R11 count down", {16'h0, cur_cnt_o[31:16]}, 32'h0000);
        chk("R11 address up", {16'h0, cur_addr_o[31:16]}, 32'h0011);
        do_step(4'b0010);
        @(negedge clk);
        chk("R12 wrap", {16'h0, cur_cnt_o[31:16]}, 32'hFFFF);
        chk("R12 addr continues", {16'h0, cur_addr_o[31:16]}, 32'h0012);
        chk("R12 base kept", {16'h0, base_cnt_o[31:16]}, 32'h0001);
        rd_chk("R12 tc flag ch1", 4'h8, 8'h02);
        rd_chk("R10 flag cleared", 4'h8, 8'h00);

        bus_wr(4'hB, 8'h74);
        @(negedge clk);
        chk("R7 ch0 mode", {26'h0, mode_o[5:0]}, 32'h1D);
        bus_wr(4'h1, 8'h01); bus_wr(4'h1, 8'h00);
        bus_wr(4'hA, 8'h00);
        @(negedge clk);
        chk("R5 unmask ch0", {28'h0, mask_o}, 32'hC);
        do_step(4'b0001);
        @(negedge clk);
        chk("R11 address down", {16'h0, cur_addr_o[15:0]}, 32'h12A9);
        do_step(4'b0001);
        @(negedge clk);
        chk("R12 reload count", {16'h0, cur_cnt_o[15:0]}, 32'h0001);
        chk("R12 reload address", {16'h0, cur_addr_o[15:0]}, 32'h12AA);
        rd_chk("R12 tc flag ch0", 4'h8, 8'h01);

        do_step(4'b0001);
        begin
            logic [7:0] d;
            @(negedge clk);
            cs_i = 1; rd_i = 1; addr_i = 4'h8; step_i = 4'b0001;
            #2 d = rdata_o;
            @(posedge clk); #1;
            cs_i = 0; rd_i = 0; step_i = 0;
            chk("R10 read before same-cycle flag", {24'h0, d}, 32'h0);
        end
        rd_chk("R10 same-cycle flag kept", 4'h8, 8'h01);

        bus_wr(4'hF, 8'h0A);
        @(negedge clk);
        chk("R6 load all masks", {28'h0, mask_o}, 32'hA);
        bus_wr(4'hE, 8'h00);
        @(negedge clk);
        chk("R6 clear all masks", {28'h0, mask_o}, 32'h0);
        bus_wr(4'h8, 8'h5A);
        @(negedge clk);
        chk("R13 command", {24'h0, cmd_o}, 32'h5A);
        bus_wr(4'h9, 8'h07);
        @(negedge clk);
        chk("R9 request ch3", {28'h0, req_o}, 32'h8);

        rd_chk("R3 ch2 low before clear", 4'h4, 8'h77);
        bus_wr(4'hD, 8'h00);
        @(negedge clk);
        chk("R8 masks", {28'h0, mask_o}, 32'hF);
        chk("R8 modes", {8'h0, mode_o}, 32'h0);
        chk("R8 cmd/req", {20'h0, cmd_o, req_o}, 32'h0);
        rd_chk("R8 pointer low", 4'h4, 8'h77);
        rd_chk("R8 status", 4'h8, 8'h00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule